// File: doc/BRIEF.md
# Runtime-Programmable Sum-of-Products Array

This block is a small field-loadable logic device. The primary inputs and the outputs fed back from the macrocells each supply a true and a complemented literal. These literals enter a programmable AND plane. Each output owns a fixed group of product terms and ORs them together, so any truth table over the literals can be written in sum-of-products form. The OR result then passes through a per-output macrocell. The macrocell either drives the result straight out, registers it in a D flip-flop, or drives it through a three-state buffer whose enable is a product term of its own.

All fuses and macrocell mode fields form one configuration vector. That vector is shifted in serially while `cfg_en` is high. `cfg_clk` and `cfg_en` are sampled by the array clock `clk`, so every control input is expected to be synchronous to it. While loading, and until a load has completed, every output is released (high impedance). When `cfg_en` drops, the array is activated and `cfg_done` goes high.

Top module: `pla_array`

## Requirements
- R1: A synchronous reset (`rst` high at a `clk` edge) clears the configuration vector, every macrocell flip-flop and `cfg_done`, so that after reset all `pin_oe` bits are 0.
- R2: While `cfg_en` is high, each rising transition of `cfg_clk` seen at a `clk` edge shifts `cfg_data` into bit 0 of the configuration vector, so the first bit sent ends at the top. Fuse bit `(o*(N_PT+1)+t)*2*(N_IN+N_OUT) + 2*k + c` joins source `k` to term `t` of output `o`: the true form when `c`=0 and the complement when `c`=1. Sources 0..N_IN-1 are `in_i` and source N_IN+j is the feedback of output j. The 2-bit mode of output `o` sits at bit offset `N_TERM*2*(N_IN+N_OUT) + 2*o`.
- R3: `pin_oe` is all zero while `cfg_done` is 0. `cfg_done` is 0 in the cycle after `cfg_en` is sampled high. It rises one cycle after the first `clk` edge at which `cfg_en` is sampled low after having been high.
- R4: A set fuse bit connects its literal, and a product term is the AND of its connected literals. A term with no connected literal is 1, and a term connecting a literal together with its complement is 0.
- R5: Output `o` takes the OR of its terms 0..N_PT-1. Term N_PT of each output is kept apart as its enable term.
- R6: Mode 00 (and the spare code 11) drives the OR result combinationally on `pin_val`, with `pin_oe` at 1 once configured.
- R7: Mode 01 drives `pin_val` from the macrocell flip-flop, with `pin_oe` at 1. The flip-flop loads the OR result on every `clk` edge while the array is active, and holds 0 until one cycle after `cfg_done` rises.
- R8: Mode 10 drives the OR result on `pin_val`, and `pin_oe` equals that output's enable term (term N_PT).
- R9: The feedback literal of output j always comes from its macrocell flip-flop, whatever the mode, and never from the pin.
- R10: While `cfg_en` is low, `cfg_clk` and `cfg_data` leave the configuration vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Configuration window; array inactive while high |
| cfg_clk | input | 1 | Configuration shift strobe, sampled by clk |
| cfg_data | input | 1 | Serial configuration bit |
| in_i | input | N_IN | Primary inputs |
| pin_val | output | N_OUT | Macrocell output values |
| pin_oe | output | N_OUT | Output enables |
| pin | output | N_OUT | Three-state pads: pin_val where pin_oe is 1, else high impedance |
| cfg_done | output | 1 | Configuration complete, array active |

## Verification
The bound checker runs every cycle. It checks that outputs stay released until configuration completes, the timing of `cfg_done` around `cfg_en`, and that the configuration vector stays frozen outside the loading window. It also checks that each flip-flop and every registered pin carry the previous cycle's OR result, and that three-state enables follow their enable terms. Only the bench scenarios can show that the bit layout and the AND/OR semantics give the right logic functions. They load real maps and sweep all 256 input patterns against computed functions (AND, OR of terms, majority, the empty and contradictory terms, the enable terms). They also run a 2-bit counter and a toggling output built purely from feedback.

// File: rtl/pla_pkg.sv
package pla_pkg;
    // macrocell mode field encoding
    typedef enum logic [1:0] {
        MC_COMB = 2'b00,
        MC_REG  = 2'b01,
        MC_TRI  = 2'b10,
        MC_SPARE = 2'b11
    } mc_mode_e;
endpackage

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_LIT  = 24,
    parameter int N_TERM = 32
) (
    input  logic [N_LIT-1:0]        lit_i,
    input  logic [N_TERM*N_LIT-1:0] fuse_i,
    output logic [N_TERM-1:0]       term_o
);
    // a cleared fuse removes the literal; an empty term therefore reads 1
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        assign term_o[t] = &(~fuse_i[t*N_LIT +: N_LIT] | lit_i);
    end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_OUT = 4,
    parameter int N_PT  = 7
) (
    input  logic [N_OUT*(N_PT+1)-1:0] term_i,
    output logic [N_OUT-1:0]          sum_o,
    output logic [N_OUT-1:0]          oe_term_o
);
    localparam int GRP = N_PT + 1;

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        assign sum_o[o]     = |term_i[o*GRP +: N_PT];
        assign oe_term_o[o] = term_i[o*GRP + N_PT];
    end
endmodule

// File: rtl/pla_macrocell.sv
module pla_macrocell
    import pla_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       sum_i,
    input  logic       oe_term_i,
    input  logic       flop_i,
    input  logic       active_i,
    output logic       val_o,
    output logic       oe_o
);
    always_comb begin
        val_o = sum_i;
        oe_o  = active_i;
        case (mc_mode_e'(mode_i))
            MC_REG:  val_o = flop_i;
            MC_TRI:  oe_o  = active_i & oe_term_i;
            default: ;
        endcase
    end
endmodule

// File: rtl/pla_array.sv
module pla_array
    import pla_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_OUT = 4,
    parameter int N_PT  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_clk,
    input  logic             cfg_data,
    input  logic [N_IN-1:0]  in_i,
    output logic [N_OUT-1:0] pin_val,
    output logic [N_OUT-1:0] pin_oe,
    output wire  [N_OUT-1:0] pin,
    output logic             cfg_done
);
    localparam int N_SRC  = N_IN + N_OUT;
    localparam int N_LIT  = 2 * N_SRC;
    localparam int GRP    = N_PT + 1;
    localparam int N_TERM = N_OUT * GRP;
    localparam int FUSE_W = N_TERM * N_LIT;
    localparam int MAP_W  = FUSE_W + 2 * N_OUT;

    typedef struct packed {
        logic [MAP_W-1:0] map;
        logic [N_OUT-1:0] mc;
        logic             done;
        logic             strobe_prev;
        logic             en_prev;
    } state_t;

    state_t s_d, s_q;

    logic [MAP_W-1:0]   map_q;
    logic [N_OUT-1:0]   mc_q;
    logic [2*N_OUT-1:0] mode_flat;
    logic [N_SRC-1:0]   src_w;
    logic [N_LIT-1:0]   lit_w;
    logic [N_TERM-1:0]  term_w;
    logic [N_OUT-1:0]   sum_w;
    logic [N_OUT-1:0]   oe_term_w;

    assign map_q     = s_q.map;
    assign mc_q      = s_q.mc;
    assign cfg_done  = s_q.done;
    assign mode_flat = map_q[MAP_W-1:FUSE_W];

    // feedback is taken from the macrocell flops, never from the pins
    assign src_w = {mc_q, in_i};

    for (genvar k = 0; k < N_SRC; k++) begin : g_lit
        assign lit_w[2*k]     = src_w[k];
        assign lit_w[2*k + 1] = ~src_w[k];
    end

    pla_and_plane #(
        .N_LIT  (N_LIT),
        .N_TERM (N_TERM)
    ) u_and (
        .lit_i  (lit_w),
        .fuse_i (map_q[FUSE_W-1:0]),
        .term_o (term_w)
    );

    pla_or_plane #(
        .N_OUT (N_OUT),
        .N_PT  (N_PT)
    ) u_or (
        .term_i    (term_w),
        .sum_o     (sum_w),
        .oe_term_o (oe_term_w)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_mc
        pla_macrocell u_mc (
            .mode_i    (mode_flat[2*o +: 2]),
            .sum_i     (sum_w[o]),
            .oe_term_i (oe_term_w[o]),
            .flop_i    (mc_q[o]),
            .active_i  (s_q.done),
            .val_o     (pin_val[o]),
            .oe_o      (pin_oe[o])
        );
        assign pin[o] = pin_oe[o] ? pin_val[o] : 1'bz;
    end

    always_comb begin
        s_d             = s_q;
        s_d.strobe_prev = cfg_clk;
        s_d.en_prev     = cfg_en;
        if (cfg_en) begin
            s_d.done = 1'b0;
            s_d.mc   = '0;
            if (cfg_clk && !s_q.strobe_prev) begin
                s_d.map = {s_q.map[MAP_W-2:0], cfg_data};
            end
        end else begin
            if (s_q.en_prev) begin
                s_d.done = 1'b1;
            end
            s_d.mc = s_q.done ? sum_w : '0;
        end
        if (rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk
    import pla_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_OUT = 4,
    parameter int N_PT  = 7,
    parameter int MAP_W = 776
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_en,
    input logic             cfg_done,
    input logic [N_OUT-1:0] pin_oe,
    input logic [N_OUT-1:0] pin_val,
    input logic [N_OUT-1:0] sum,
    input logic [N_OUT-1:0] oe_term,
    input logic [N_OUT-1:0] mc_q,
    input logic [2*N_OUT-1:0] mode_flat,
    input logic [MAP_W-1:0] map_q,
    input logic [N_IN-1:0]  in_i
);
    p_hiz_until_done_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_done |-> pin_oe == '0);

    p_done_drops_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> !cfg_done);

    p_done_rises_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_en) |=> cfg_done);

    p_map_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(map_q));

    p_fb_capture_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_done && $past(cfg_done)) |-> mc_q == $past(sum));

    for (genvar o = 0; o < N_OUT; o++) begin : g_o
        p_reg_tracks_sum_r7: assert property (@(posedge clk) disable iff (rst)
            (cfg_done && $past(cfg_done) && mode_flat[2*o +: 2] == MC_REG)
                |-> (pin_val[o] == $past(sum[o]) && pin_oe[o]));

        p_tri_enable_r8: assert property (@(posedge clk) disable iff (rst)
            (cfg_done && mode_flat[2*o +: 2] == MC_TRI) |-> pin_oe[o] == oe_term[o]);
    end

    // inputs kept for probing the bound scope
    logic unused_in;
    assign unused_in = ^in_i;
endmodule

bind pla_array pla_array_chk #(
    .N_IN  (N_IN),
    .N_OUT (N_OUT),
    .N_PT  (N_PT),
    .MAP_W (MAP_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_en    (cfg_en),
    .cfg_done  (cfg_done),
    .pin_oe    (pin_oe),
    .pin_val   (pin_val),
    .sum       (sum_w),
    .oe_term   (oe_term_w),
    .mc_q      (mc_q),
    .mode_flat (mode_flat),
    .map_q     (map_q),
    .in_i      (in_i)
);

// File: tb/sim_pla_array.sv
`timescale 1ns/1ps
module sim_pla_array;
    localparam int N_IN   = 8;
    localparam int N_OUT  = 4;
    localparam int N_PT   = 7;
    localparam int GRP    = N_PT + 1;
    localparam int LIT_W  = 2 * (N_IN + N_OUT);
    localparam int N_TERM = N_OUT * GRP;
    localparam int FUSE_W = N_TERM * LIT_W;
    localparam int MAP_W  = FUSE_W + 2 * N_OUT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_en = 1'b0;
    logic cfg_clk = 1'b0;
    logic cfg_data = 1'b0;
    logic [N_IN-1:0] in_i = '0;
    logic [N_OUT-1:0] pin_val, pin_oe;
    wire  [N_OUT-1:0] pin;
    logic cfg_done;

    logic [MAP_W-1:0] map;
    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pla_array #(.N_IN(N_IN), .N_OUT(N_OUT), .N_PT(N_PT)) u0 (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_clk(cfg_clk),
        .cfg_data(cfg_data), .in_i(in_i), .pin_val(pin_val),
        .pin_oe(pin_oe), .pin(pin), .cfg_done(cfg_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic set_lit(input int o, input int t, input int src, input int neg);
        map[(o*GRP + t)*LIT_W + 2*src + neg] = 1'b1;
    endtask

    task automatic clear_term(input int o, input int t);
        map[(o*GRP + t)*LIT_W +: LIT_W] = '0;
    endtask

    // literal and its complement together: term forced to 0
    task automatic kill_all();
        map = '0;
        for (int o = 0; o < N_OUT; o++)
            for (int t = 0; t < GRP; t++) begin
                set_lit(o, t, 0, 0);
                set_lit(o, t, 0, 1);
            end
    endtask

    task automatic set_mode(input int o, input logic [1:0] m);
        map[FUSE_W + 2*o +: 2] = m;
    endtask

    task automatic load_map();
        @(negedge clk);
        cfg_en = 1'b1;
        cfg_clk = 1'b0;
        @(negedge clk);
        check(pin_oe == '0 && !cfg_done, "R3 released while loading", int'({pin_oe, cfg_done}), 0);
        for (int i = MAP_W - 1; i >= 0; i--) begin
            cfg_data = map[i];
            cfg_clk = 1'b0;
            @(negedge clk);
            cfg_clk = 1'b1;
            @(negedge clk);
        end
        cfg_clk = 1'b0;
        @(negedge clk);
        check(!cfg_done && pin_oe == '0, "R3 still inactive before cfg_en drops", int'(cfg_done), 0);
        cfg_en = 1'b0;
        @(negedge clk);
        check(cfg_done == 1'b1, "R3 done after cfg_en low", int'(cfg_done), 1);
    endtask

    function automatic bit maj3(input logic [N_IN-1:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

    task automatic sweep_map1(input string tag);
        for (int v = 0; v < 256; v++) begin
            logic [N_IN-1:0] x;
            bit e0, e2, e3v, e3oe;
            x = v[N_IN-1:0];
            in_i = x;
            #2;
            e0 = (x[0] & x[1] & x[2]) | (x[6] & x[7]);
            e2 = maj3(x);
            e3v = x[3];
            e3oe = x[4] & ~x[5];
            check(pin_val[0] == e0 && pin_oe[0], {tag, " R2/R5 out0 and-or"}, int'({pin_oe[0], pin_val[0]}), int'({1'b1, e0}));
            check(pin_val[1] == 1'b1 && pin_oe[1], {tag, " R4 empty term is 1"}, int'({pin_oe[1], pin_val[1]}), 3);
            check(pin_val[2] == e2 && pin_oe[2], {tag, " R6 majority comb"}, int'({pin_oe[2], pin_val[2]}), int'({1'b1, e2}));
            check(pin_val[3] == e3v && pin_oe[3] == e3oe, {tag, " R8 tri enable"}, int'({pin_oe[3], pin_val[3]}), int'({e3oe, e3v}));
            @(negedge clk);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                finished = 1'b1;
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [1:0] cnt_prev;
        logic tog_prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pin_oe == '0 && !cfg_done, "R1 reset state", int'({pin_oe, cfg_done}), 0);
        check(pin_oe == '0, "R3 released before first load", int'(pin_oe), 0);

        // map 1: out0 = in0&in1&in2 | in6&in7, out1 = empty term, out2 = majority, out3 tri
        kill_all();
        clear_term(0, 0); set_lit(0, 0, 0, 0); set_lit(0, 0, 1, 0); set_lit(0, 0, 2, 0);
        clear_term(0, 2); set_lit(0, 2, 6, 0); set_lit(0, 2, 7, 0);
        clear_term(1, 3);
        clear_term(2, 0); set_lit(2, 0, 0, 0); set_lit(2, 0, 1, 0);
        clear_term(2, 1); set_lit(2, 1, 0, 0); set_lit(2, 1, 2, 0);
        clear_term(2, 5); set_lit(2, 5, 1, 0); set_lit(2, 5, 2, 0);
        clear_term(3, 0); set_lit(3, 0, 3, 0);
        clear_term(3, N_PT); set_lit(3, N_PT, 4, 0); set_lit(3, N_PT, 5, 1);
        set_mode(0, 2'b00); set_mode(1, 2'b00); set_mode(2, 2'b00); set_mode(3, 2'b10);
        load_map();
        sweep_map1("map1");

        // R10: strobes with cfg_en low must not disturb the map
        for (int i = 0; i < 20; i++) begin
            cfg_data = i[0] ^ i[2];
            cfg_clk = ~cfg_clk;
            @(negedge clk);
        end
        cfg_clk = 1'b0;
        for (int v = 0; v < 8; v++) begin
            in_i = N_IN'(v * 37);
            #2;
            check(pin_val[2] == maj3(in_i) && pin_oe[3] == (in_i[4] & ~in_i[5]),
                  "R10 map unchanged by strobes", int'(pin_val), int'(maj3(in_i)));
            @(negedge clk);
        end

        // map 2: 2-bit counter on out1:out0, comb toggle on out2, spare mode on out3
        kill_all();
        clear_term(0, 0); set_lit(0, 0, N_IN + 0, 1);
        clear_term(1, 0); set_lit(1, 0, N_IN + 1, 0); set_lit(1, 0, N_IN + 0, 1);
        clear_term(1, 1); set_lit(1, 1, N_IN + 1, 1); set_lit(1, 1, N_IN + 0, 0);
        clear_term(2, 0); set_lit(2, 0, N_IN + 2, 1);
        clear_term(3, 0); set_lit(3, 0, 0, 0);
        set_mode(0, 2'b01); set_mode(1, 2'b01); set_mode(2, 2'b00); set_mode(3, 2'b11);
        in_i = '0;
        load_map();
        check(pin_val[1:0] == 2'd0 && pin_oe[1:0] == 2'b11, "R7 flops start at 0", int'(pin_val[1:0]), 0);
        cnt_prev = pin_val[1:0];
        tog_prev = pin_val[2];
        for (int i = 0; i < 12; i++) begin
            in_i[0] = i[1];
            @(negedge clk);
            #1;
            check(pin_val[1:0] == cnt_prev + 2'd1, "R7/R9 registered counter", int'(pin_val[1:0]), int'(cnt_prev + 2'd1));
            check(pin_val[2] == ~tog_prev, "R9 comb output feedback via flop", int'(pin_val[2]), int'(~tog_prev));
            check(pin_val[3] == in_i[0] && pin_oe[3], "R6 spare mode acts combinational", int'(pin_val[3]), int'(in_i[0]));
            cnt_prev = pin_val[1:0];
            tog_prev = pin_val[2];
        end

        // mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(pin_oe == '0 && !cfg_done, "R1 reset after activity", int'({pin_oe, cfg_done}), 0);
        rst = 1'b0;
        @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule